// File: doc/BRIEF.md
# Packed 4:2:2 to RGB Stream Converter

This block turns a stream of packed 4:2:2 video words into a stream of 24-bit colour pixels. Each 32-bit input word carries two luma samples and one chroma pair that both pixels share. The block emits the two pixels on consecutive clock cycles. Each channel is computed by a fixed-point multiply-accumulate with coefficients scaled by 256, rounded, and then saturated to one byte.

Both edges use valid/ready handshakes and honour backpressure fully. Frame width and height are run-time inputs. An internal position tracker flags the last pixel of every line and the last pixel of every frame, so a downstream writer can find line and frame boundaries without counting pixels itself. The word input runs at half the pixel rate. A steady input stream therefore produces one pixel on every clock.

Top module: `pix422_to_rgb`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: An input word is read as bits [7:0] first luma, [15:8] U, [23:16] second luma, [31:24] V. It produces two output pixels in that luma order, and both use the same U and V.
- R3: With c = Y-16, d = U-128, e = V-128, each channel is (k_c*c + k_d*d + k_e*e + 128) >> 8 with an arithmetic shift. The coefficients are: red 298, 517, 0; green 298, -100, -208; blue 298, 0, 409.
- R4: Each channel result is clamped to 0..255. For example, Y=U=V=255 gives red 255, green 125, blue 255. Y=U=V=0 gives red 0, green 135, blue 0.
- R5: out_pixel holds blue in bits [7:0], green in [15:8] and red in [23:16].
- R6: No input word is accepted on two consecutive cycles. With in_valid and out_ready held high, one pixel leaves on every cycle once the stream is running.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pixel, out_eol and out_eof stay unchanged on the next cycle. No pixel is lost or repeated.
- R8: frame_w and frame_h must each be at least 1. out_eol is 1 exactly on the frame_w-th pixel of each line.
- R9: out_eof is 1 only on the last pixel of line number frame_h. The next pixel after it starts a new frame at line 1, pixel 1.
- R10: The pipeline may be empty while out_ready is high. If a word is accepted at clock edge k in that state, out_valid is 0 after edge k, and after edge k+1 it is 1 with that word's first pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_w | input | DIM_W | Pixels per line, at least 1 |
| frame_h | input | DIM_W | Lines per frame, at least 1 |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Packed word: luma0, U, luma1, V from the low byte up |
| in_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_pixel | output | 24 | Blue low byte, green middle, red high byte |
| out_eol | output | 1 | Pixel is the last of its line |
| out_eof | output | 1 | Pixel is the last of its frame |

## Verification
A word accepted into an empty block with the output free shows its first pixel after the next clock edge, one edge later than the acceptance edge. The second pixel follows on the edge after that. The latency scenario samples out_valid half a cycle after each of those two edges and expects 0 and then 1. All other results are taken from a monitor that logs each output handshake with its cycle number. Pixel values, line and frame flags, and the one-pixel-per-cycle rate are then checked against the arrival order and the cycle gaps, not against fixed delays. During backpressure the held pixel is sampled half a cycle after every stalled edge.

// File: rtl/yuv2rgb_pkg.sv
package yuv2rgb_pkg;
  localparam int COMP_W     = 8;
  localparam int WORD_W     = 4 * COMP_W;
  localparam int NCH        = 3;
  localparam int PIX_W      = NCH * COMP_W;
  localparam int FRAC_W     = 8;
  localparam int ACC_W      = 2 * COMP_W + 4;
  localparam int LUMA_OFS   = 16;
  localparam int CHROMA_OFS = 128;
  localparam int K_Y        = 298;

  // channel index 0 = blue, 1 = green, 2 = red (matches output packing)
  localparam int signed K_U [NCH] = '{0, -100, 517};
  localparam int signed K_V [NCH] = '{409, -208, 0};

  function automatic logic [COMP_W-1:0] sat_shift(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] sh;
    sh = (acc + ACC_W'(1 << (FRAC_W - 1))) >>> FRAC_W;
    if (sh < 0)
      return '0;
    else if (sh > (2 ** COMP_W - 1))
      return '1;
    else
      return sh[COMP_W-1:0];
  endfunction
endpackage

// File: rtl/ycc_unpack.sv
module ycc_unpack
  import yuv2rgb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              take,
  output logic              pix_valid,
  output logic [COMP_W-1:0] pix_y,
  output logic [COMP_W-1:0] pix_u,
  output logic [COMP_W-1:0] pix_v
);
  logic              hold_q, hold_n;
  logic              second_q, second_n;
  logic [WORD_W-1:0] word_q;
  logic              accept;

  // a new word may enter only when the holding stage is empty or its second
  // pixel leaves this very cycle
  always_comb begin
    in_ready = !hold_q || (second_q && take);
    accept   = in_valid && in_ready;
    hold_n   = hold_q;
    second_n = second_q;
    if (accept) begin
      hold_n   = 1'b1;
      second_n = 1'b0;
    end else if (take) begin
      if (second_q) begin
        hold_n   = 1'b0;
        second_n = 1'b0;
      end else begin
        second_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      second_q <= 1'b0;
    end else begin
      hold_q   <= hold_n;
      second_q <= second_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) word_q <= in_word;
  end

  always_comb begin
    pix_valid = hold_q;
    pix_y     = second_q ? word_q[2*COMP_W +: COMP_W] : word_q[0 +: COMP_W];
    pix_u     = word_q[1*COMP_W +: COMP_W];
    pix_v     = word_q[3*COMP_W +: COMP_W];
  end
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
  import yuv2rgb_pkg::*;
(
  input  logic [COMP_W-1:0] y,
  input  logic [COMP_W-1:0] u,
  input  logic [COMP_W-1:0] v,
  output logic [PIX_W-1:0]  pix
);
  logic signed [ACC_W-1:0] dy, du, dv;

  always_comb begin
    dy = $signed(ACC_W'(y)) - ACC_W'(LUMA_OFS);
    du = $signed(ACC_W'(u)) - ACC_W'(CHROMA_OFS);
    dv = $signed(ACC_W'(v)) - ACC_W'(CHROMA_OFS);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic signed [ACC_W-1:0] KY = ACC_W'(K_Y);
    localparam logic signed [ACC_W-1:0] KU = ACC_W'(K_U[ch]);
    localparam logic signed [ACC_W-1:0] KV = ACC_W'(K_V[ch]);
    logic signed [ACC_W-1:0] acc;

    always_comb acc = KY * dy + KU * du + KV * dv;
    assign pix[ch*COMP_W +: COMP_W] = sat_shift(acc);
  end
endmodule

// File: rtl/ycc_position.sv
module ycc_position #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  output logic             last_col,
  output logic             last_row
);
  logic [DIM_W-1:0] col_q, col_n;
  logic [DIM_W-1:0] row_q, row_n;

  always_comb begin
    last_col = (col_q == frame_w - DIM_W'(1));
    last_row = (row_q == frame_h - DIM_W'(1));
    col_n    = col_q;
    row_n    = row_q;
    if (step) begin
      if (last_col) begin
        col_n = '0;
        row_n = last_row ? '0 : row_q + DIM_W'(1);
      end else begin
        col_n = col_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      col_q <= col_n;
      row_q <= row_n;
    end
  end
endmodule

// File: rtl/pix422_to_rgb.sv
module pix422_to_rgb
  import yuv2rgb_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              out_eol,
  output logic              out_eof
);
  logic              pix_valid;
  logic [COMP_W-1:0] pix_y, pix_u, pix_v;
  logic [PIX_W-1:0]  rgb;
  logic              last_col, last_row;
  logic              adv, take;
  logic              vld_q, vld_n;
  logic [PIX_W-1:0]  pix_q;
  logic              eol_q, eof_q;

  ycc_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .in_ready (in_ready),
    .take     (take),
    .pix_valid(pix_valid),
    .pix_y    (pix_y),
    .pix_u    (pix_u),
    .pix_v    (pix_v)
  );

  ycc_matrix u_matrix (
    .y  (pix_y),
    .u  (pix_u),
    .v  (pix_v),
    .pix(rgb)
  );

  ycc_position #(.DIM_W(DIM_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (take),
    .frame_w (frame_w),
    .frame_h (frame_h),
    .last_col(last_col),
    .last_row(last_row)
  );

  always_comb begin
    adv   = !vld_q || out_ready;
    take  = pix_valid && adv;
    vld_n = adv ? pix_valid : vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      pix_q <= rgb;
      eol_q <= last_col;
      eof_q <= last_col && last_row;
    end
  end

  assign out_valid = vld_q;
  assign out_pixel = pix_q;
  assign out_eol   = eol_q;
  assign out_eof   = eof_q;
endmodule

// File: rtl/pix422_to_rgb_chk.sv
module pix422_to_rgb_chk #(
  parameter int DIM_W = 12,
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIM_W-1:0] frame_w,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pixel,
  input logic             out_eol,
  input logic             out_eof
);
  logic [DIM_W-1:0] run_q;
  logic             hs;

  assign hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  run_q <= '0;
    else if (hs) run_q <= out_eol ? '0 : run_q + DIM_W'(1);
  end

  p_no_back2back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel) &&
                                   $stable(out_eol) && $stable(out_eof)));

  p_eol_cadence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_eol) |-> (run_q == frame_w - DIM_W'(1)));

  p_eof_on_eol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> out_eol);

  p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);
endmodule

bind pix422_to_rgb pix422_to_rgb_chk #(.DIM_W(DIM_W), .PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_w  (frame_w),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pixel(out_pixel),
  .out_eol  (out_eol),
  .out_eof  (out_eof)
);

// File: tb/pix422_to_rgb_tb.sv
module pix422_to_rgb_tb;
  localparam int DIM_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIM_W-1:0] frame_w = 12'd4;
  logic [DIM_W-1:0] frame_h = 12'd2;
  logic             in_valid = 1'b0;
  logic [31:0]      in_word = '0;
  logic             in_ready;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [23:0]      out_pixel;
  logic             out_eol, out_eof;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_got = 0;
  logic [23:0] got_pix [256];
  logic        got_eol [256];
  logic        got_eof [256];
  int          got_cyc [256];
  logic [31:0] tx_word [64];
  int          acc_cyc [64];

  always #5 clk = ~clk;

  pix422_to_rgb #(.DIM_W(DIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_w(frame_w), .frame_h(frame_h),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_eol(out_eol), .out_eof(out_eof)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && n_got < 256) begin
      got_pix[n_got] = out_pixel;
      got_eol[n_got] = out_eol;
      got_eof[n_got] = out_eof;
      got_cyc[n_got] = cyc;
      n_got = n_got + 1;
    end
  end

  function automatic int clamp8(input int x);
    if (x < 0) return 0;
    if (x > 255) return 255;
    return x;
  endfunction

  function automatic logic [23:0] model(input int y, input int u, input int v);
    int c, d, e, r, g, b;
    c = y - 16; d = u - 128; e = v - 128;
    r = clamp8((298 * c + 517 * d + 128) >>> 8);
    g = clamp8((298 * c - 100 * d - 208 * e + 128) >>> 8);
    b = clamp8((298 * c + 409 * e + 128) >>> 8);
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic logic [31:0] mk(input int y0, input int u, input int y1, input int v);
    return {v[7:0], y1[7:0], u[7:0], y0[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_words(input int cnt);
    int i = 0;
    while (i < cnt) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = tx_word[i];
      @(posedge clk);
      if (in_ready) begin
        acc_cyc[i] = cyc;
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_n(input int target);
    for (int k = 0; k < 200 && n_got < target; k++) @(negedge clk);
    @(negedge clk);
  endtask

  // check the pixels of a run against the model of the words sent
  task automatic check_pixels(input int base, input int words, input string req);
    for (int i = 0; i < words; i++) begin
      logic [31:0] w;
      w = tx_word[i];
      check(got_pix[base+2*i] === model(w[7:0], w[15:8], w[31:24]), req,
            got_pix[base+2*i], model(w[7:0], w[15:8], w[31:24]));
      check(got_pix[base+2*i+1] === model(w[23:16], w[15:8], w[31:24]), req,
            got_pix[base+2*i+1], model(w[23:16], w[15:8], w[31:24]));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_basic;
    int base = n_got;
    frame_w = 4; frame_h = 2;
    tx_word[0] = mk(16, 128, 235, 128);
    tx_word[1] = mk(81, 90, 145, 240);
    tx_word[2] = mk(41, 240, 200, 110);
    tx_word[3] = mk(170, 166, 60, 16);
    push_words(4);
    wait_n(base + 8);
    check(n_got == base + 8, "R2 pixel count", n_got - base, 8);
    check_pixels(base, 4, "R2 R3 R5 pixel value");
    // black and white greys: blue in low byte
    check(got_pix[base] === 24'h000000, "R5 black", got_pix[base], 0);
    check(got_pix[base+1] === 24'hFFFFFF, "R5 white", got_pix[base+1], 24'hFFFFFF);
    for (int i = 0; i < 8; i++) begin
      check(got_eol[base+i] === (i == 3 || i == 7), "R8 eol position", got_eol[base+i], (i == 3 || i == 7));
      check(got_eof[base+i] === (i == 7), "R9 eof position", got_eof[base+i], (i == 7));
    end
  endtask

  task automatic t_clamp;
    int base = n_got;
    frame_w = 2; frame_h = 2;
    tx_word[0] = mk(255, 255, 255, 255);
    tx_word[1] = mk(0, 0, 0, 0);
    push_words(2);
    wait_n(base + 4);
    check(got_pix[base] === {8'd255, 8'd125, 8'd255}, "R4 high clamp", got_pix[base], {8'd255, 8'd125, 8'd255});
    check(got_pix[base+2] === {8'd0, 8'd135, 8'd0}, "R4 low clamp", got_pix[base+2], {8'd0, 8'd135, 8'd0});
    check(got_pix[base+1] === got_pix[base], "R2 shared chroma", got_pix[base+1], got_pix[base]);
  endtask

  task automatic t_latency;
    int base = n_got;
    logic [31:0] w;
    frame_w = 2; frame_h = 1;
    w = mk(100, 60, 180, 200);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(posedge clk);
    check(in_ready === 1'b1, "R10 accepted when empty", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b0, "R10 not valid after accept edge", out_valid, 0);
    @(negedge clk);
    check(out_valid === 1'b1, "R10 valid one edge later", out_valid, 1);
    check(out_pixel === model(100, 60, 200), "R10 first pixel", out_pixel, model(100, 60, 200));
    wait_n(base + 2);
    check(got_pix[base+1] === model(180, 60, 200), "R2 second luma", got_pix[base+1], model(180, 60, 200));
    check(got_eof[base+1] === 1'b1, "R9 single-line frame eof", got_eof[base+1], 1);
  endtask

  task automatic t_backpressure;
    int base = n_got;
    logic [23:0] held;
    frame_w = 2; frame_h = 2;
    tx_word[0] = mk(50, 70, 90, 110);
    tx_word[1] = mk(130, 150, 170, 190);
    out_ready = 1'b0;
    fork push_words(2); join_none
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1, "R7 valid under stall", out_valid, 1);
    held = out_pixel;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_pixel === held, "R7 held pixel", out_pixel, held);
    end
    check(in_ready === 1'b0, "R7 input stalled", in_ready, 0);
    out_ready = 1'b1;
    wait fork;
    wait_n(base + 4);
    check(n_got == base + 4, "R7 no loss", n_got - base, 4);
    check_pixels(base, 2, "R7 order after stall");
  endtask

  task automatic t_throughput;
    int base = n_got;
    int bad_gap = 0;
    int bad_rate = 0;
    frame_w = 8; frame_h = 2;
    for (int i = 0; i < 8; i++) tx_word[i] = mk(20 + 25 * i, 30 + 20 * i, 40 + 24 * i, 200 - 20 * i);
    push_words(8);
    wait_n(base + 16);
    for (int i = 0; i < 7; i++) if (acc_cyc[i+1] - acc_cyc[i] < 2) bad_gap++;
    for (int i = 1; i < 16; i++) if (got_cyc[base+i] - got_cyc[base+i-1] != 1) bad_rate++;
    check(bad_gap == 0, "R6 no back-to-back accepts", bad_gap, 0);
    check(bad_rate == 0, "R6 one pixel per cycle", bad_rate, 0);
    check_pixels(base, 8, "R6 stream values");
    check(got_eol[base+7] === 1'b1 && got_eof[base+7] === 1'b0, "R8 mid-frame eol", {got_eol[base+7], got_eof[base+7]}, 2);
    check(got_eof[base+15] === 1'b1, "R9 eof wide frame", got_eof[base+15], 1);
  endtask

  task automatic t_frames;
    int base = n_got;
    frame_w = 2; frame_h = 2;
    for (int i = 0; i < 4; i++) tx_word[i] = mk(60 + i, 128, 90 + i, 128);
    push_words(4);
    wait_n(base + 8);
    for (int i = 0; i < 8; i++) begin
      check(got_eol[base+i] === (i % 2 == 1), "R8 eol two frames", got_eol[base+i], (i % 2 == 1));
      check(got_eof[base+i] === (i == 3 || i == 7), "R9 counter restart", got_eof[base+i], (i == 3 || i == 7));
    end
  endtask

  task automatic run_all;
    t_reset();
    t_basic();
    t_clamp();
    t_latency();
    t_backpressure();
    t_throughput();
    t_frames();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule